// File: doc/BRIEF.md
# Pin Fault Insertion Array

This block sits in series on every pin between a processor and the socket it normally plugs into. In normal running each path copies the value from its source side to its destination side and drives nothing back. When a fault command is active, the pins picked by a per-pin selection vector are corrupted in the way a 3-bit fault-kind code asks for. Every pin also reports its fault-free value on a separate tap, so that later analysis can tell whether a fault changed anything without any analog sensing of the pin.

The pins come in three groups, fixed by parameters. The lowest `NBIDIR` pins are two-way, and a direction bit per pin picks which side is the source. The highest `NIN` pins are one-way inputs, driven from the socket towards the processor. All pins in between are one-way outputs, driven from the processor towards the socket. The fault command is taken in on a clock edge, so a corruption lasts a whole number of clock cycles. The trace clock of the surrounding injector drives that clock.

Top module: `fi_pin_array`

## Requirements
- R1: While no fault command is active, every pin's destination side carries its source value, with the drive enable set.
- R2: The fault command (strobe, kind, selection vector, external values) is sampled on the rising clock edge and acts from that edge until the next one. An active-low asynchronous reset clears it at once.
- R3: Only pins whose selection bit is 1 are corrupted. Every other pin behaves as in R1, whatever the fault kind.
- R4: Kind code 0 forces the selected pins to 0, and code 1 forces them to 1.
- R5: Kind code 2 drives each selected pin with its own bit of the external-value vector.
- R6: Kind code 3 drives each selected pin with the inverse of its source value.
- R7: Kind code 4 drives a selected pin with the AND of its source value and the source value of the pin one index higher. Code 5 does the same with the pin one index lower. The array does not wrap: the highest pin under code 4 and pin 0 under code 5 pass through unchanged.
- R8: Kind code 6 clears the drive enable on the destination side of each selected pin.
- R9: Kind code 7 is reserved and leaves the selected pins passing through.
- R10: The clean tap of each pin always equals its source-side value, with or without a fault.
- R11: Pins [0, NBIDIR) are two-way, with direction bit 1 meaning processor-to-socket. Pins [NPINS-NIN, NPINS) run socket-to-processor, and all other pins run processor-to-socket. Only the destination side of a pin ever asserts its enable, and it is the only side that carries a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the fault command |
| rst_n | input | 1 | Asynchronous active-low reset, clears the command |
| flt_strobe_i | input | 1 | Fault command active for the next cycle |
| flt_kind_i | input | 3 | Fault kind code (0 stuck-0, 1 stuck-1, 2 external, 3 invert, 4 AND with next, 5 AND with previous, 6 open, 7 reserved) |
| flt_sel_i | input | NPINS | Per-pin selection vector |
| flt_ext_i | input | NPINS | Per-pin value used by kind 2 |
| dir_i | input | NBIDIR | Direction of the two-way pins, 1 = processor to socket |
| cpu_in_i | input | NPINS | Values the processor drives |
| cpu_out_o | output | NPINS | Values driven towards the processor |
| cpu_oe_o | output | NPINS | Drive enables towards the processor |
| skt_in_i | input | NPINS | Values the socket side drives |
| skt_out_o | output | NPINS | Values driven towards the socket |
| skt_oe_o | output | NPINS | Drive enables towards the socket |
| clean_o | output | NPINS | Fault-free value of each pin |

## Verification
The bench targets the two ends of the array under bridging. It uses patterns where only the end pin is high. A design that wrapped round would AND that pin with a low value from the far end and clear it. Bridging is also run inside a short run of ones, where the last one must fall and the rest must stay. This would catch a design that took its neighbour from the faulted value or from the wrong side. Two-way pins are flipped in direction with different values on the two sides. A design that drove both sides, corrupted the source side, or took the clean tap after the fault would show a wrong enable, a wrong value or a wrong tap. The one-cycle command latency and the asynchronous clear are also probed, before and after the edge and in the middle of an active fault.

// File: rtl/fi_pkg.sv
package fi_pkg;

    // Fault kind codes; the numeric values are part of the block's interface.
    typedef enum logic [2:0] {
        FK_STUCK0   = 3'd0,
        FK_STUCK1   = 3'd1,
        FK_EXTVAL   = 3'd2,
        FK_INVERT   = 3'd3,
        FK_AND_NEXT = 3'd4,
        FK_AND_PREV = 3'd5,
        FK_OPEN     = 3'd6,
        FK_RSVD     = 3'd7
    } fkind_e;

endpackage

// File: rtl/fi_cmd_reg.sv
module fi_cmd_reg
    import fi_pkg::*;
#(
    parameter int NPINS = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [2:0]       kind_i,
    input  logic [NPINS-1:0] sel_i,
    input  logic [NPINS-1:0] ext_i,
    output logic [NPINS-1:0] hit_o,
    output fkind_e           kind_o,
    output logic [NPINS-1:0] ext_o
);

    typedef struct packed {
        logic             armed;
        fkind_e           kind;
        logic [NPINS-1:0] sel;
        logic [NPINS-1:0] ext;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    // Next-state: a strobe loads the whole command; otherwise only disarm,
    // keeping the last kind and vectors stable to save toggling.
    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.armed = strobe_i;
        if (strobe_i) begin
            cmd_d.kind = fkind_e'(kind_i);
            cmd_d.sel  = sel_i;
            cmd_d.ext  = ext_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{armed: 1'b0, kind: FK_RSVD, sel: '0, ext: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign hit_o  = {NPINS{cmd_q.armed}} & cmd_q.sel;
    assign kind_o = cmd_q.kind;
    assign ext_o  = cmd_q.ext;

endmodule

// File: rtl/fi_pin_elem.sv
module fi_pin_elem
    import fi_pkg::*;
(
    input  logic   outward_i,   // 1: processor side is the source
    input  logic   src_i,       // fault-free pin value
    input  logic   nbr_prev_i,  // clean value of lower neighbour (1 if none)
    input  logic   nbr_next_i,  // clean value of upper neighbour (1 if none)
    input  logic   hit_i,       // fault active on this pin
    input  fkind_e kind_i,
    input  logic   ext_i,
    output logic   cpu_out_o,
    output logic   cpu_oe_o,
    output logic   skt_out_o,
    output logic   skt_oe_o
);

    logic faulty;
    logic drive;

    always_comb begin
        faulty = src_i;
        drive  = 1'b1;
        if (hit_i) begin
            case (kind_i)
                FK_STUCK0:   faulty = 1'b0;
                FK_STUCK1:   faulty = 1'b1;
                FK_EXTVAL:   faulty = ext_i;
                FK_INVERT:   faulty = ~src_i;
                FK_AND_NEXT: faulty = src_i & nbr_next_i;
                FK_AND_PREV: faulty = src_i & nbr_prev_i;
                FK_OPEN:     drive  = 1'b0;
                default:     faulty = src_i;
            endcase
        end
    end

    // Only the destination side is driven, and only it carries the fault.
    assign skt_out_o = outward_i & faulty;
    assign skt_oe_o  = outward_i & drive;
    assign cpu_out_o = ~outward_i & faulty;
    assign cpu_oe_o  = ~outward_i & drive;

endmodule

// File: rtl/fi_pin_array.sv
module fi_pin_array
    import fi_pkg::*;
#(
    parameter int NPINS  = 96,
    parameter int NBIDIR = 32,
    parameter int NIN    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_strobe_i,
    input  logic [2:0]        flt_kind_i,
    input  logic [NPINS-1:0]  flt_sel_i,
    input  logic [NPINS-1:0]  flt_ext_i,
    input  logic [NBIDIR-1:0] dir_i,
    input  logic [NPINS-1:0]  cpu_in_i,
    output logic [NPINS-1:0]  cpu_out_o,
    output logic [NPINS-1:0]  cpu_oe_o,
    input  logic [NPINS-1:0]  skt_in_i,
    output logic [NPINS-1:0]  skt_out_o,
    output logic [NPINS-1:0]  skt_oe_o,
    output logic [NPINS-1:0]  clean_o
);

    localparam int FIRST_IN = NPINS - NIN;

    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] ext;
    fkind_e           kind;
    logic [NPINS-1:0] outward;
    logic [NPINS-1:0] src;

    fi_cmd_reg #(.NPINS(NPINS)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (flt_strobe_i),
        .kind_i   (flt_kind_i),
        .sel_i    (flt_sel_i),
        .ext_i    (flt_ext_i),
        .hit_o    (hit),
        .kind_o   (kind),
        .ext_o    (ext)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic nbr_prev;
        logic nbr_next;

        if (i < NBIDIR) begin : g_two_way
            assign outward[i] = dir_i[i];
        end else if (i < FIRST_IN) begin : g_out
            assign outward[i] = 1'b1;
        end else begin : g_in
            assign outward[i] = 1'b0;
        end

        assign src[i] = outward[i] ? cpu_in_i[i] : skt_in_i[i];

        // Missing neighbours read as 1, making the AND a pass-through.
        if (i == 0) begin : g_lo_end
            assign nbr_prev = 1'b1;
        end else begin : g_lo_mid
            assign nbr_prev = src[i-1];
        end
        if (i == NPINS - 1) begin : g_hi_end
            assign nbr_next = 1'b1;
        end else begin : g_hi_mid
            assign nbr_next = src[i+1];
        end

        fi_pin_elem u_elem (
            .outward_i  (outward[i]),
            .src_i      (src[i]),
            .nbr_prev_i (nbr_prev),
            .nbr_next_i (nbr_next),
            .hit_i      (hit[i]),
            .kind_i     (kind),
            .ext_i      (ext[i]),
            .cpu_out_o  (cpu_out_o[i]),
            .cpu_oe_o   (cpu_oe_o[i]),
            .skt_out_o  (skt_out_o[i]),
            .skt_oe_o   (skt_oe_o[i])
        );
    end

    assign clean_o = src;

endmodule

// File: rtl/fi_pin_array_chk.sv
module fi_pin_array_chk #(
    parameter int NPINS = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flt_strobe_i,
    input logic [2:0]       flt_kind_i,
    input logic [NPINS-1:0] flt_sel_i,
    input logic [NPINS-1:0] cpu_out_o,
    input logic [NPINS-1:0] cpu_oe_o,
    input logic [NPINS-1:0] skt_out_o,
    input logic [NPINS-1:0] skt_oe_o,
    input logic [NPINS-1:0] clean_o
);

    logic [NPINS-1:0] dval;
    logic [NPINS-1:0] doe;

    assign dval = (skt_out_o & skt_oe_o) | (cpu_out_o & cpu_oe_o);
    assign doe  = skt_oe_o | cpu_oe_o;

    assert_pass_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flt_strobe_i)) |-> (dval == clean_o && doe == '1));

    assert_mask_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((dval ^ clean_o) | ~doe) & ~$past(flt_sel_i)) == '0);

    assert_stuck0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flt_strobe_i) && $past(flt_kind_i) == 3'd0)
        |-> ((dval & $past(flt_sel_i)) == '0));

    assert_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flt_strobe_i) && $past(flt_kind_i) == 3'd3)
        |-> ((dval ^ clean_o) == $past(flt_sel_i)));

    assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flt_strobe_i) && $past(flt_kind_i) == 3'd6)
        |-> (doe == ~$past(flt_sel_i)));

    assert_one_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (skt_oe_o & cpu_oe_o) == '0);

endmodule

bind fi_pin_array fi_pin_array_chk #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_strobe_i (flt_strobe_i),
    .flt_kind_i   (flt_kind_i),
    .flt_sel_i    (flt_sel_i),
    .cpu_out_o    (cpu_out_o),
    .cpu_oe_o     (cpu_oe_o),
    .skt_out_o    (skt_out_o),
    .skt_oe_o     (skt_oe_o),
    .clean_o      (clean_o)
);

// File: tb/sim_fi_pin_array.sv
module sim_fi_pin_array;

    localparam int NP = 96;
    localparam int NB = 32;
    localparam logic [NP-1:0] ONES = {NP{1'b1}};
    localparam logic [NP-1:0] ZERO = '0;
    localparam logic [NP-1:0] C0   = 96'h0123_4567_89AB_CDEF_0F0F_F0F0;
    localparam logic [NB-1:0] DIR_LO = 32'h0000_FFFF;

    typedef struct packed {
        logic          stb;
        logic [2:0]    kind;
        logic [NP-1:0] sel;
        logic [NP-1:0] ext;
        logic [NP-1:0] cval;
        logic [NP-1:0] eval;
        logic [NP-1:0] eoe;
        logic [23:0]   tag;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 3'd1, ONES, ZERO, C0, C0, ONES, "R1 "},
        '{1'b1, 3'd0, 96'h0000_0000_FFFF_FFFF_0000_0000, ZERO, ONES,
          96'hFFFF_FFFF_0000_0000_FFFF_FFFF, ONES, "R4 "},
        '{1'b1, 3'd1, 96'hF000_0000_0000_0000_0000_000F, ZERO, ZERO,
          96'hF000_0000_0000_0000_0000_000F, ONES, "R4 "},
        '{1'b1, 3'd2, 96'h0000_FFFF_0000_FFFF_0000_FFFF,
          96'h1234_5678_9ABC_DEF0_1357_9BDF, ZERO,
          96'h0000_5678_0000_DEF0_0000_9BDF, ONES, "R5 "},
        '{1'b1, 3'd3, 96'hFFFF_0000_0000_0000_0000_FFFF, ZERO,
          96'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA,
          96'h5555_AAAA_AAAA_AAAA_AAAA_5555, ONES, "R6 "},
        '{1'b1, 3'd4, 96'h0000_0000_0000_0000_0000_00FF, ZERO,
          96'hF000_0000_0000_0000_0000_00F0,
          96'hF000_0000_0000_0000_0000_0070, ONES, "R7 "},
        '{1'b1, 3'd5, 96'h0000_0000_0000_0000_0000_00FF, ZERO,
          96'hF000_0000_0000_0000_0000_00F0,
          96'hF000_0000_0000_0000_0000_00E0, ONES, "R7 "},
        '{1'b1, 3'd4, ONES, ZERO, 96'h8000_0000_0000_0000_0000_0000,
          96'h8000_0000_0000_0000_0000_0000, ONES, "R7 "},
        '{1'b1, 3'd5, ONES, ZERO, 96'h0000_0000_0000_0000_0000_0001,
          96'h0000_0000_0000_0000_0000_0001, ONES, "R7 "},
        '{1'b1, 3'd6, 96'h0000_0000_0000_0000_FFFF_0000, ZERO, ONES,
          96'hFFFF_FFFF_FFFF_FFFF_0000_FFFF,
          96'hFFFF_FFFF_FFFF_FFFF_0000_FFFF, "R8 "},
        '{1'b1, 3'd7, ONES, ZERO, C0, C0, ONES, "R9 "},
        '{1'b1, 3'd3, ZERO, ZERO, C0, C0, ONES, "R3 "},
        '{1'b0, 3'd3, ONES, ZERO, C0, C0, ONES, "R1 "}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe = 1'b0;
    logic [2:0]    kind = 3'd0;
    logic [NP-1:0] sel = '0;
    logic [NP-1:0] ext = '0;
    logic [NB-1:0] dir = '0;
    logic [NP-1:0] cpu_in = '0;
    logic [NP-1:0] skt_in = '0;
    logic [NP-1:0] cpu_out, cpu_oe, skt_out, skt_oe, clean;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fi_pin_array #(.NPINS(NP), .NBIDIR(NB), .NIN(8)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .flt_strobe_i (strobe),
        .flt_kind_i   (kind),
        .flt_sel_i    (sel),
        .flt_ext_i    (ext),
        .dir_i        (dir),
        .cpu_in_i     (cpu_in),
        .cpu_out_o    (cpu_out),
        .cpu_oe_o     (cpu_oe),
        .skt_in_i     (skt_in),
        .skt_out_o    (skt_out),
        .skt_oe_o     (skt_oe),
        .clean_o      (clean)
    );

    function automatic logic [NP-1:0] dest_val();
        return (skt_out & skt_oe) | (cpu_out & cpu_oe);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_cmd(input logic s, input logic [2:0] k, input logic [NP-1:0] m,
                             input logic [NP-1:0] e);
        strobe = s; kind = k; sel = m; ext = e;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R2: reset holds the command cleared even with an invert strobe present.
        drive_cmd(1'b1, 3'd3, ONES, ZERO);
        cpu_in = C0; skt_in = C0; dir = '0;
        repeat (2) @(posedge clk);
        #1;
        chk("R2", "reset pass", dest_val(), C0);
        chk("R2", "reset oe", skt_oe | cpu_oe, ONES);
        @(negedge clk);
        drive_cmd(1'b0, 3'd0, ZERO, ZERO);
        rst_n = 1'b1;

        // Vector table walk.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            drive_cmd(TBL[v].stb, TBL[v].kind, TBL[v].sel, TBL[v].ext);
            cpu_in = TBL[v].cval; skt_in = TBL[v].cval; dir = DIR_LO;
            @(posedge clk);
            #1;
            chk(string'(TBL[v].tag), $sformatf("vec%0d value", v), dest_val(), TBL[v].eval);
            chk(string'(TBL[v].tag), $sformatf("vec%0d enable", v), skt_oe | cpu_oe, TBL[v].eoe);
            chk("R10", $sformatf("vec%0d clean", v), clean, TBL[v].cval);
        end

        // R2: one-cycle latency of the command.
        @(negedge clk);
        drive_cmd(1'b1, 3'd3, ONES, ZERO);
        cpu_in = C0; skt_in = C0;
        #1;
        chk("R2", "before edge", dest_val(), C0);
        @(posedge clk); #1;
        chk("R2", "after edge", dest_val(), ~C0);
        @(negedge clk);
        drive_cmd(1'b0, 3'd3, ONES, ZERO);
        #1;
        chk("R2", "held to edge", dest_val(), ~C0);
        @(posedge clk); #1;
        chk("R2", "released", dest_val(), C0);

        // R11: direction steering of two-way pins and fixed one-way groups.
        @(negedge clk);
        cpu_in = ONES; skt_in = ZERO; dir = DIR_LO;
        @(posedge clk); #1;
        chk("R11", "skt_oe dir lo", skt_oe, 96'h00FF_FFFF_FFFF_FFFF_0000_FFFF);
        chk("R11", "cpu_oe dir lo", cpu_oe, 96'hFF00_0000_0000_0000_FFFF_0000);
        chk("R11", "skt_out dir lo", skt_out, 96'h00FF_FFFF_FFFF_FFFF_0000_FFFF);
        chk("R11", "cpu_out dir lo", cpu_out, ZERO);
        chk("R10", "clean dir lo", clean, 96'h00FF_FFFF_FFFF_FFFF_0000_FFFF);
        @(negedge clk);
        dir = 32'hFFFF_0000;
        #1;
        chk("R11", "skt_oe dir hi", skt_oe, 96'h00FF_FFFF_FFFF_FFFF_FFFF_0000);
        chk("R10", "clean dir hi", clean, 96'h00FF_FFFF_FFFF_FFFF_FFFF_0000);

        // R11: fault lands on the processor side of an inward two-way pin.
        @(negedge clk);
        cpu_in = ZERO; skt_in = ZERO; dir = DIR_LO;
        drive_cmd(1'b1, 3'd3, 96'h0000_0000_0000_0000_0010_0000, ZERO);
        @(posedge clk); #1;
        chk("R11", "inward cpu_out", cpu_out, 96'h0000_0000_0000_0000_0010_0000);
        chk("R11", "inward skt_out", skt_out, ZERO);
        chk("R10", "inward clean", clean, ZERO);

        // R2: asynchronous reset clears an active fault at once.
        @(negedge clk);
        cpu_in = C0; skt_in = C0;
        drive_cmd(1'b1, 3'd3, ONES, ZERO);
        @(posedge clk); #1;
        chk("R6", "pre-reset invert", dest_val(), ~C0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R2", "async clear", dest_val(), C0);
        drive_cmd(1'b0, 3'd0, ZERO, ZERO);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "after reset", dest_val(), C0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule